// File: doc/BRIEF.md
# Two-Write Sequenced Reset Controller

This block sits on a local write bus and turns a two-step write sequence into a timed reset of the local processor card. The first write arms the controller and the second write fires it. Bit 1 of the written byte selects the reset type: when it is set, the CPU reset, the PCI reset (active low) and the ISA reset-drive outputs pulse together. When it is clear, only the processor INIT output pulses. Bit 2 is the go bit. It must be 0 in the arming write and 1 in the firing write.

The sequence is accepted on two paths. On the I/O path, both writes go to the single I/O register at 0xCF9. On the memory path, the arming write goes to 0xFFFFFFF0 and the firing write goes to 0xFFFFFFF4. The memory path lets an agent that can only issue memory writes restart the card. Only the local reset outputs are driven, so anything beyond the card keeps its state.

A read-back value shows the last accepted write. During a pulse it holds the firing value. The value drops to 0x00 when the pulse ends.

Top module: `seq_reset_ctrl`

## Requirements
- R1: A write with bit 2 = 1 and bit 1 = 1 to a firing address, after an arming write with bit 2 = 0 and bit 1 = 1 (for example 0x02 then 0x06), starts a hard reset on the next clock edge.
- R2: A write with bit 2 = 1 and bit 1 = 0 to a firing address, after an arming write with bit 2 = 0 and bit 1 = 0 (0x00 then 0x04), starts a soft reset on the next clock edge.
- R3: During a hard reset, cpu_rst_o and isa_rst_o are 1, pci_rst_no is 0 and cpu_init_o is 0. All three outputs hold for exactly HARD_CYCLES cycles (default 1024) and then release together.
- R4: During a soft reset, cpu_init_o is 1 for exactly INIT_CYCLES cycles (16). The three hard-reset outputs stay idle throughout.
- R5: I/O path: a write with wr_io_i = 1 and wr_addr_i = 0xCF9 counts as both an arming address and a firing address.
- R6: Memory path: with wr_io_i = 0, address 0xFFFFFFF0 arms and address 0xFFFFFFF4 fires.
- R7: rd_data_o shows the last accepted write to a reset address, with bit 2 forced to 0 when no pulse starts. During a pulse it shows the firing value, and it reads 0x00 once the pulse ends.
- R8: A firing-style write produces no pulse when the controller is not armed, or when its bit 1 differs from the arming write.
- R9: Any write to a reset address that does not complete the sequence clears the armed state. Writes to other addresses, and I/O writes to the memory addresses, change nothing.
- R10: rst_ni low clears the armed state and sets rd_data_o to 0x00. It leaves cpu_rst_o, isa_rst_o and cpu_init_o at 0 and pci_rst_no at 1.
- R11: Writes that arrive while a pulse runs are ignored. They do not change rd_data_o and do not arm the controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data; bit 1 = mode, bit 2 = go |
| rd_data_o | output | DATA_W | Register read-back value |
| cpu_rst_o | output | 1 | Processor hard reset |
| pci_rst_no | output | 1 | PCI reset, active low |
| isa_rst_o | output | 1 | ISA reset drive |
| cpu_init_o | output | 1 | Processor INIT (soft reset) |

## Verification
The bench targets the cases where a sloppy decoder would fire wrongly:
- A firing value written with no arm would start a stray pulse.
- A hard arm followed by a soft fire would give the wrong reset type, or a pulse at all.
- A firing value sent to the arming memory address would keep the arm alive, so a later firing write would start a pulse.
- An I/O write that aliases a memory address would behave like a reset address.

A scoreboard measures every pulse and checks its length against its type. An off-by-one counter therefore shows up as a pulse one cycle too long or too short. A design that listens during a pulse would show a changed read-back value or an extra INIT pulse after a hard reset. A design that keeps the arm through reset would fire on the first write after it.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int unsigned MODE_BIT = 1;  // 1 = hard, 0 = soft
  localparam int unsigned GO_BIT   = 2;

  typedef struct packed {
    logic any_slot;
    logic arm_slot;
    logic fire_slot;
  } slot_hit_t;
endpackage

// File: rtl/rstc_decode.sv
module rstc_decode #(
  parameter int unsigned           ADDR_W    = 32,
  parameter logic [ADDR_W-1:0]     IO_ADDR   = 'h0CF9,
  parameter logic [ADDR_W-1:0]     ARM_ADDR  = 'hFFFF_FFF0,
  parameter logic [ADDR_W-1:0]     FIRE_ADDR = 'hFFFF_FFF4
) (
  input  logic                 wr_io_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  output rstc_pkg::slot_hit_t  hit_o
);
  logic io_hit, mem_arm_hit, mem_fire_hit;

  always_comb begin
    io_hit          = wr_io_i  && (wr_addr_i == IO_ADDR);
    mem_arm_hit     = !wr_io_i && (wr_addr_i == ARM_ADDR);
    mem_fire_hit    = !wr_io_i && (wr_addr_i == FIRE_ADDR);
    hit_o.arm_slot  = io_hit | mem_arm_hit;
    hit_o.fire_slot = io_hit | mem_fire_hit;
    hit_o.any_slot  = io_hit | mem_arm_hit | mem_fire_hit;
  end
endmodule

// File: rtl/rstc_seq.sv
module rstc_seq #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  rstc_pkg::slot_hit_t hit_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                busy_i,
  input  logic                done_i,
  output logic                start_o,
  output logic                start_hard_o,
  output logic [DATA_W-1:0]   reg_o
);
  import rstc_pkg::*;

  logic              armed_q, armed_hard_q;
  logic [DATA_W-1:0] reg_q, masked;
  logic              accept, fire;

  always_comb begin
    masked         = wr_data_i;
    masked[GO_BIT] = 1'b0;
    accept         = wr_en_i && !busy_i && hit_i.any_slot;
    fire           = accept && hit_i.fire_slot && armed_q && wr_data_i[GO_BIT]
                     && (wr_data_i[MODE_BIT] == armed_hard_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q      <= 1'b0;
      armed_hard_q <= 1'b0;
      reg_q        <= '0;
    end else if (done_i) begin
      reg_q <= '0;
    end else if (accept) begin
      if (fire) begin
        reg_q   <= wr_data_i;
        armed_q <= 1'b0;
      end else begin
        // anything short of a completing write re-evaluates the arm
        reg_q        <= masked;
        armed_q      <= hit_i.arm_slot && !wr_data_i[GO_BIT];
        armed_hard_q <= wr_data_i[MODE_BIT];
      end
    end
  end

  assign start_o      = fire;
  assign start_hard_o = wr_data_i[MODE_BIT];
  assign reg_o        = reg_q;
endmodule

// File: rtl/rstc_timer.sv
module rstc_timer #(
  parameter int unsigned HARD_CYCLES = 1024,
  parameter int unsigned INIT_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic hard_i,
  output logic active_o,
  output logic hard_o,
  output logic done_o
);
  localparam int unsigned MAX_C = (HARD_CYCLES > INIT_CYCLES) ? HARD_CYCLES : INIT_CYCLES;
  localparam int unsigned CNT_W = $clog2(MAX_C) + 1;
  localparam logic [CNT_W-1:0] HARD_LOAD = CNT_W'(HARD_CYCLES - 1);
  localparam logic [CNT_W-1:0] INIT_LOAD = CNT_W'(INIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q, hard_q;

  assign done_o = active_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      hard_q   <= 1'b0;
    end else if (start_i && !active_q) begin
      cnt_q    <= hard_i ? HARD_LOAD : INIT_LOAD;
      active_q <= 1'b1;
      hard_q   <= hard_i;
    end else if (done_o) begin
      active_q <= 1'b0;
      hard_q   <= 1'b0;
    end else if (active_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = active_q;
  assign hard_o   = hard_q;
endmodule

// File: rtl/seq_reset_ctrl.sv
module seq_reset_ctrl #(
  parameter int unsigned        ADDR_W      = 32,
  parameter int unsigned        DATA_W      = 8,
  parameter int unsigned        HARD_CYCLES = 1024,
  parameter int unsigned        INIT_CYCLES = 16,
  parameter logic [ADDR_W-1:0]  IO_ADDR     = 'h0CF9,
  parameter logic [ADDR_W-1:0]  ARM_ADDR    = 'hFFFF_FFF0,
  parameter logic [ADDR_W-1:0]  FIRE_ADDR   = 'hFFFF_FFF4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_io_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              cpu_rst_o,
  output logic              pci_rst_no,
  output logic              isa_rst_o,
  output logic              cpu_init_o
);
  rstc_pkg::slot_hit_t hit;
  logic start, start_hard, active, hard, done;

  rstc_decode #(
    .ADDR_W(ADDR_W), .IO_ADDR(IO_ADDR), .ARM_ADDR(ARM_ADDR), .FIRE_ADDR(FIRE_ADDR)
  ) u_decode (
    .wr_io_i  (wr_io_i),
    .wr_addr_i(wr_addr_i),
    .hit_o    (hit)
  );

  rstc_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .hit_i       (hit),
    .wr_data_i   (wr_data_i),
    .busy_i      (active),
    .done_i      (done),
    .start_o     (start),
    .start_hard_o(start_hard),
    .reg_o       (rd_data_o)
  );

  rstc_timer #(.HARD_CYCLES(HARD_CYCLES), .INIT_CYCLES(INIT_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .hard_i  (start_hard),
    .active_o(active),
    .hard_o  (hard),
    .done_o  (done)
  );

  assign cpu_rst_o  = active & hard;
  assign isa_rst_o  = active & hard;
  assign pci_rst_no = ~(active & hard);
  assign cpu_init_o = active & ~hard;
endmodule

// File: rtl/seq_reset_ctrl_chk.sv
module seq_reset_ctrl_chk #(
  parameter int unsigned HARD_CYCLES = 1024,
  parameter int unsigned INIT_CYCLES = 16,
  parameter int unsigned DATA_W      = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              wr_go_i,
  input logic              wr_mode_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              cpu_rst_o,
  input logic              pci_rst_no,
  input logic              isa_rst_o,
  input logic              cpu_init_o
);
  localparam int unsigned CW = $clog2(HARD_CYCLES + INIT_CYCLES + 1) + 1;
  logic [CW-1:0] h_cnt, s_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_cnt <= '0;
      s_cnt <= '0;
    end else begin
      h_cnt <= cpu_rst_o  ? h_cnt + 1'b1 : '0;
      s_cnt <= cpu_init_o ? s_cnt + 1'b1 : '0;
    end
  end

  AST_HARD_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_o) |-> $past(wr_en_i && wr_go_i && wr_mode_i)); // R1
  AST_SOFT_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_init_o) |-> $past(wr_en_i && wr_go_i && !wr_mode_i)); // R2
  AST_HARD_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rst_o == isa_rst_o) && (pci_rst_no == !cpu_rst_o)); // R3
  AST_HARD_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_rst_o) |-> (h_cnt == CW'(HARD_CYCLES))); // R3
  AST_SOFT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_init_o |-> !cpu_rst_o && !isa_rst_o && pci_rst_no); // R4
  AST_SOFT_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_init_o) |-> (s_cnt == CW'(INIT_CYCLES))); // R4
  AST_REG_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cpu_rst_o) || $fell(cpu_init_o)) |-> (rd_data_o == '0)); // R7
  AST_REG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cpu_rst_o || cpu_init_o) && (cpu_rst_o || cpu_init_o)) |-> $stable(rd_data_o)); // R11
endmodule

bind seq_reset_ctrl seq_reset_ctrl_chk #(
  .HARD_CYCLES(HARD_CYCLES), .INIT_CYCLES(INIT_CYCLES), .DATA_W(DATA_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_go_i   (wr_data_i[2]),
  .wr_mode_i (wr_data_i[1]),
  .rd_data_o (rd_data_o),
  .cpu_rst_o (cpu_rst_o),
  .pci_rst_no(pci_rst_no),
  .isa_rst_o (isa_rst_o),
  .cpu_init_o(cpu_init_o)
);

// File: tb/seq_reset_ctrl_tb.sv
module seq_reset_ctrl_tb;
  localparam int HARD = 1024;
  localparam int SOFT = 16;
  localparam logic [31:0] A_IO   = 32'h0000_0CF9;
  localparam logic [31:0] A_ARM  = 32'hFFFF_FFF0;
  localparam logic [31:0] A_FIRE = 32'hFFFF_FFF4;

  typedef struct { bit hard; int len; } pulse_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_io = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic cpu_rst, pci_rst_n, isa_rst, cpu_init;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;
  pulse_t exp_q[$];

  always #2 clk = ~clk;

  seq_reset_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_io_i(wr_io),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .cpu_rst_o(cpu_rst), .pci_rst_no(pci_rst_n), .isa_rst_o(isa_rst),
    .cpu_init_o(cpu_init)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic io, input logic [31:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_io = io; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_pulse(input bit hard);
    pulse_t p;
    p.hard = hard;
    p.len  = hard ? HARD : SOFT;
    exp_q.push_back(p);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_pulse(input bit hard, input int len, input bit bad);
    pulse_t p;
    string req;
    req = hard ? "R3" : "R4";
    if (exp_q.size() == 0) begin
      n_chk++; n_fail++;
      $display("FAIL %s unexpected pulse actual=%0d expected=none", req, len);
    end else begin
      p = exp_q.pop_front();
      chk(req, {31'd0, hard}, {31'd0, p.hard});
      chk(req, len, p.len);
      chk(req, {31'd0, bad}, 32'd0);
    end
  endtask

  // scoreboard monitor
  int h_len = 0, s_len = 0;
  bit h_bad = 0, s_bad = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      h_len = 0; s_len = 0; h_bad = 0; s_bad = 0;
    end else begin
      if (cpu_rst) begin
        h_len++;
        if (isa_rst !== 1'b1 || pci_rst_n !== 1'b0 || cpu_init !== 1'b0) h_bad = 1;
      end else if (h_len > 0) begin
        finish_pulse(1'b1, h_len, h_bad);
        h_len = 0; h_bad = 0;
      end
      if (cpu_init) begin
        s_len++;
        if (cpu_rst !== 1'b0 || isa_rst !== 1'b0 || pci_rst_n !== 1'b1) s_bad = 1;
      end else if (s_len > 0) begin
        finish_pulse(1'b0, s_len, s_bad);
        s_len = 0; s_bad = 0;
      end
    end
  end

  task automatic summary;
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    // R10 reset state
    chk("R10 rd", {24'd0, rd_data}, 32'h0);
    chk("R10 outs", {28'd0, cpu_rst, pci_rst_n, isa_rst, cpu_init}, 32'b0100);

    // I/O hard reset, with ignored writes during the pulse
    expect_pulse(1'b1);
    wr(1'b1, A_IO, 8'h02);
    chk("R7 arm value", {24'd0, rd_data}, 32'h02);
    wr(1'b1, A_IO, 8'h06);
    chk("R1 R5 hard start", {31'd0, cpu_rst}, 32'd1);
    chk("R7 during pulse", {24'd0, rd_data}, 32'h06);
    wr(1'b1, A_IO, 8'h00);
    wr(1'b1, A_IO, 8'h04);
    chk("R11 reg held", {24'd0, rd_data}, 32'h06);
    idle(HARD + 4);
    chk("R7 cleared", {24'd0, rd_data}, 32'h0);
    chk("R11 no soft after", {31'd0, cpu_init}, 32'd0);

    // I/O soft reset
    expect_pulse(1'b0);
    wr(1'b1, A_IO, 8'h00);
    wr(1'b1, A_IO, 8'h04);
    chk("R2 R5 soft start", {31'd0, cpu_init}, 32'd1);
    chk("R4 no hard", {31'd0, cpu_rst}, 32'd0);
    idle(SOFT + 4);
    chk("R7 cleared soft", {24'd0, rd_data}, 32'h0);

    // memory path, both types
    expect_pulse(1'b1);
    wr(1'b0, A_ARM, 8'h02);
    wr(1'b0, A_FIRE, 8'h06);
    chk("R6 mem hard", {31'd0, cpu_rst}, 32'd1);
    idle(HARD + 4);
    expect_pulse(1'b0);
    wr(1'b0, A_ARM, 8'h00);
    wr(1'b0, A_FIRE, 8'h04);
    chk("R6 mem soft", {31'd0, cpu_init}, 32'd1);
    idle(SOFT + 4);

    // fire without arm
    wr(1'b1, A_IO, 8'h06);
    chk("R8 go masked", {24'd0, rd_data}, 32'h02);
    idle(4);
    chk("R8 unarmed", {30'd0, cpu_rst, cpu_init}, 32'd0);

    // mode mismatch
    wr(1'b1, A_IO, 8'h00);
    wr(1'b1, A_IO, 8'h06);
    idle(4);
    chk("R8 mismatch", {30'd0, cpu_rst, cpu_init}, 32'd0);

    // interrupted sequence
    wr(1'b0, A_ARM, 8'h02);
    wr(1'b0, A_ARM, 8'h06);
    chk("R9 rd", {24'd0, rd_data}, 32'h02);
    wr(1'b0, A_FIRE, 8'h06);
    idle(4);
    chk("R9 disarmed", {30'd0, cpu_rst, cpu_init}, 32'd0);

    // unrelated writes keep the arm
    wr(1'b0, A_ARM, 8'h02);
    wr(1'b0, 32'h0000_1000, 8'h06);
    wr(1'b1, A_FIRE, 8'h00);
    chk("R9 other addr", {24'd0, rd_data}, 32'h02);
    expect_pulse(1'b1);
    wr(1'b0, A_FIRE, 8'h06);
    chk("R9 arm kept", {31'd0, cpu_rst}, 32'd1);
    idle(HARD + 4);

    // reset drops the arm
    wr(1'b1, A_IO, 8'h00);
    @(negedge clk) rst_n = 1'b0;
    idle(2);
    @(negedge clk) rst_n = 1'b1;
    chk("R10 rd after rst", {24'd0, rd_data}, 32'h0);
    wr(1'b1, A_IO, 8'h04);
    idle(4);
    chk("R10 arm cleared", {30'd0, cpu_rst, cpu_init}, 32'd0);

    chk("R3 R4 scoreboard drained", exp_q.size(), 32'd0);
    summary();
  end
endmodule